// File: doc/BRIEF.md
# Video Command Stream Expander

The expander sits between a word FIFO and a serial video transmitter. Its input is a compact list of 32-bit words. Some are commands and some are data. It turns the list into one output word per cycle for as long as work is pending. A command word names an operation and an item count. The operations are:

- pass the next N words through once;
- repeat a single word N times;
- send N words down the pixel path;
- repeat a single pixel word N times;
- do nothing.

Each emitted word carries a tag that tells the stages after it whether the word is a ready-made line symbol group (raw) or pixel data for encoding. This lets a short table describe a whole blanking line in a handful of words. For example, porch and sync intervals can be built from repeated control-symbol words, followed by a pixel run taken from a frame buffer.

The input side is a valid/ready handshake. The output side has no backpressure: `out_valid` marks the cycles that carry a word. Output is registered, so a word leaves exactly one cycle after the cycle in which it was accepted or produced.

Top module: `vid_cmd_expander`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is low and `in_ready` is high, so the block is idle and waiting for a command.
- R2: A command word decodes its opcode from bits [15:12] and its count N from bits [11:0]; bits [31:16] are ignored. Opcode 0x0 makes the next N accepted words leave once each, in order, with `out_is_pixel` low. Every bit of each word leaves unmodified, including the three 10-bit lane symbols at [9:0], [19:10] and [29:20].
- R3: Opcode 0x1 with N>0 takes one data word and emits it on N consecutive cycles with `out_is_pixel` low. `in_ready` is low for the N-1 cycles after that word is accepted.
- R4: Opcode 0x2 makes the next N accepted words leave once each, in order, with `out_is_pixel` high.
- R5: Opcode 0x3 with N>0 takes one data word and emits it on N consecutive cycles with `out_is_pixel` high. `in_ready` is low for the N-1 cycles after that word is accepted.
- R6: Opcode 0xF consumes only its command word and emits nothing. The next accepted word is decoded as a command.
- R7: Opcodes 0x4 to 0xE behave exactly as opcode 0xF, whatever their count field holds.
- R8: A command with N=0 consumes no data words and emits nothing. The next accepted word is decoded as a command.
- R9: While a command still has words to take and no input word is offered, `out_valid` stays low and the remaining count is kept.
- R10: A data word accepted in cycle t appears on `out_data` in cycle t+1. A command word itself never produces output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block takes the offered word this cycle |
| in_data | input | 32 | Command or data word |
| out_valid | output | 1 | Output word present this cycle |
| out_data | output | 32 | Emitted word |
| out_is_pixel | output | 1 | High for pixel-path words, low for raw symbol words |

## Verification
The assertions assume that `in_data` is meaningful only when `in_valid` is high. They also assume that a word, once offered, stays on the bus until `in_ready` takes it. The bench drives only at falling edges and holds each word until it is taken. It inserts idle gaps between words of a command, so the stall behaviour is reached without breaking that rule. Every opcode value is swept with counts of zero, one, two, three and seven. Random upper command bits and random data words are used, with a long repeat at the largest count.

// File: rtl/vcx_pkg.sv
package vcx_pkg;

    // Opcode values carried in the field just above the count.
    localparam int VCX_OPC_RAW     = 0;
    localparam int VCX_OPC_RAW_RPT = 1;
    localparam int VCX_OPC_PIX     = 2;
    localparam int VCX_OPC_PIX_RPT = 3;

    // Decoded command class; every undefined opcode folds into CLS_SKIP.
    typedef enum logic [2:0] {
        CLS_SKIP,
        CLS_RAW,
        CLS_RAW_RPT,
        CLS_PIX,
        CLS_PIX_RPT
    } vcx_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE,    // next accepted word is a command
        ST_STREAM,  // passing count words through once each
        ST_LATCH,   // waiting for the word that will be repeated
        ST_REPEAT   // replaying the held word, input blocked
    } vcx_state_e;

endpackage

// File: rtl/vcx_cmd_decode.sv
module vcx_cmd_decode
    import vcx_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int OP_W  = 4
) (
    input  logic [OP_W+CNT_W-1:0] field_i,
    output vcx_cls_e              cls_o,
    output logic [CNT_W-1:0]      cnt_o,
    output logic                  zero_o
);

    localparam logic [OP_W-1:0] K_RAW     = OP_W'(VCX_OPC_RAW);
    localparam logic [OP_W-1:0] K_RAW_RPT = OP_W'(VCX_OPC_RAW_RPT);
    localparam logic [OP_W-1:0] K_PIX     = OP_W'(VCX_OPC_PIX);
    localparam logic [OP_W-1:0] K_PIX_RPT = OP_W'(VCX_OPC_PIX_RPT);

    logic [OP_W-1:0] opcode;

    assign opcode = field_i[CNT_W +: OP_W];
    assign cnt_o  = field_i[CNT_W-1:0];
    assign zero_o = (field_i[CNT_W-1:0] == '0);

    always_comb begin
        case (opcode)
            K_RAW:     cls_o = CLS_RAW;
            K_RAW_RPT: cls_o = CLS_RAW_RPT;
            K_PIX:     cls_o = CLS_PIX;
            K_PIX_RPT: cls_o = CLS_PIX_RPT;
            default:   cls_o = CLS_SKIP;   // R6, R7: nop and undefined codes
        endcase
    end

endmodule

// File: rtl/vcx_sequencer.sv
module vcx_sequencer
    import vcx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  vcx_cls_e          cls_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              zero_i,
    output logic              in_ready,
    output logic              emit_v,
    output logic [DATA_W-1:0] emit_d,
    output logic              emit_p,
    output vcx_state_e        state_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        vcx_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              pix;
        logic [DATA_W-1:0] hold;
    } seq_t;

    seq_t seq_d, seq_q;
    logic take;

    assign take    = in_valid && in_ready;
    assign state_o = seq_q.st;

    always_comb begin
        seq_d    = seq_q;
        in_ready = (seq_q.st != ST_REPEAT);
        emit_v   = 1'b0;
        emit_d   = seq_q.hold;
        emit_p   = seq_q.pix;

        case (seq_q.st)
            ST_IDLE: begin
                if (take && !zero_i) begin
                    seq_d.cnt = cnt_i;
                    case (cls_i)
                        CLS_RAW: begin
                            seq_d.st  = ST_STREAM;
                            seq_d.pix = 1'b0;
                        end
                        CLS_PIX: begin
                            seq_d.st  = ST_STREAM;
                            seq_d.pix = 1'b1;
                        end
                        CLS_RAW_RPT: begin
                            seq_d.st  = ST_LATCH;
                            seq_d.pix = 1'b0;
                        end
                        CLS_PIX_RPT: begin
                            seq_d.st  = ST_LATCH;
                            seq_d.pix = 1'b1;
                        end
                        default: seq_d.st = ST_IDLE;
                    endcase
                end
            end
            ST_STREAM: begin
                if (take) begin
                    emit_v    = 1'b1;
                    emit_d    = in_data;
                    seq_d.cnt = seq_q.cnt - CNT_ONE;
                    if (seq_q.cnt == CNT_ONE) begin
                        seq_d.st = ST_IDLE;
                    end
                end
            end
            ST_LATCH: begin
                if (take) begin
                    emit_v     = 1'b1;
                    emit_d     = in_data;
                    seq_d.hold = in_data;
                    seq_d.cnt  = seq_q.cnt - CNT_ONE;
                    seq_d.st   = (seq_q.cnt == CNT_ONE) ? ST_IDLE : ST_REPEAT;
                end
            end
            ST_REPEAT: begin
                emit_v    = 1'b1;
                seq_d.cnt = seq_q.cnt - CNT_ONE;
                if (seq_q.cnt == CNT_ONE) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, pix: 1'b0, hold: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // R9: a command that still owes words never sits at a zero count
    assert_busy_count_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE) |-> (seq_q.cnt != '0));

    // R9: with no word offered, the remaining count of a stream is kept
    assert_stall_keeps_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_STREAM && !in_valid) |=> (seq_q.st == ST_STREAM) && $stable(seq_q.cnt));

    // R3: the last replay cycle returns the block to command decoding
    assert_repeat_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_REPEAT && seq_q.cnt == CNT_ONE) |=> (seq_q.st == ST_IDLE) && in_ready);

endmodule

// File: rtl/vcx_out_stage.sv
module vcx_out_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_v,
    input  logic [DATA_W-1:0] emit_d,
    input  logic              emit_p,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_is_pixel
);

    typedef struct packed {
        logic              v;
        logic [DATA_W-1:0] d;
        logic              p;
    } ostg_t;

    ostg_t ostg_d, ostg_q;

    always_comb begin
        ostg_d = ostg_q;
        ostg_d.v = emit_v;
        if (emit_v) begin
            ostg_d.d = emit_d;
            ostg_d.p = emit_p;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ostg_q <= '0;
        end else begin
            ostg_q <= ostg_d;
        end
    end

    assign out_valid    = ostg_q.v;
    assign out_data     = ostg_q.d;
    assign out_is_pixel = ostg_q.p;

endmodule

// File: rtl/vid_cmd_expander.sv
module vid_cmd_expander
    import vcx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12,
    parameter int OP_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_is_pixel
);

    localparam int               FIELD_W = OP_W + CNT_W;
    localparam logic [OP_W-1:0]  OP_LAST_DEF = OP_W'(VCX_OPC_PIX_RPT);
    localparam logic [OP_W-1:0]  OP_NOP      = '1;

    vcx_cls_e          cls;
    logic [CNT_W-1:0]  cnt;
    logic              zero;
    logic              emit_v;
    logic [DATA_W-1:0] emit_d;
    logic              emit_p;
    vcx_state_e        st;
    logic [OP_W-1:0]   in_op;

    assign in_op = in_data[CNT_W +: OP_W];

    vcx_cmd_decode #(
        .CNT_W (CNT_W),
        .OP_W  (OP_W)
    ) dec_i (
        .field_i (in_data[FIELD_W-1:0]),
        .cls_o   (cls),
        .cnt_o   (cnt),
        .zero_o  (zero)
    );

    vcx_sequencer #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .cls_i    (cls),
        .cnt_i    (cnt),
        .zero_i   (zero),
        .in_ready (in_ready),
        .emit_v   (emit_v),
        .emit_d   (emit_d),
        .emit_p   (emit_p),
        .state_o  (st)
    );

    vcx_out_stage #(
        .DATA_W (DATA_W)
    ) ostg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .emit_v       (emit_v),
        .emit_d       (emit_d),
        .emit_p       (emit_p),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_is_pixel (out_is_pixel)
    );

    // R10: a streamed word shows up unmodified one cycle after acceptance
    assert_stream_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STREAM && in_valid && in_ready) |=> out_valid && (out_data == $past(in_data)));

    // R9: no accepted word and no replay means no output next cycle
    assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_REPEAT && !(in_valid && in_ready)) |=> !out_valid);

    // R3: replay cycles keep the same word and tag on the output
    assert_repeat_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REPEAT) |=> out_valid && $stable(out_data) && $stable(out_is_pixel));

    // R6: the all-ones opcode emits nothing and leaves the block idle
    assert_nop_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && in_valid && in_op == OP_NOP) |=> !out_valid && in_ready && (st == ST_IDLE));

    // R7: undefined opcodes behave as the nop
    assert_undef_is_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && in_valid && in_op > OP_LAST_DEF && in_op != OP_NOP)
        |=> !out_valid && in_ready && (st == ST_IDLE));

    // R8: a zero count leaves the block waiting for another command
    assert_zero_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && in_valid && in_data[CNT_W-1:0] == '0) |=> !out_valid && (st == ST_IDLE));

endmodule

// File: tb/vid_cmd_expander_tb_top.sv
`timescale 1ns/1ps
module vid_cmd_expander_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_is_pixel;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    logic [31:0] seed = 32'h1234_5679;
    logic [32:0] exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    vid_cmd_expander dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_is_pixel (out_is_pixel)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic new_word(output logic [31:0] w);
        seed = seed * 32'h0019_660D + 32'h3C6E_F35F;
        w = seed;
    endtask

    // Offer one word after gap idle cycles; hold it until taken.
    task automatic send(input logic [31:0] w, input int gap, input bit quiet, input bit emits);
        for (int i = 0; i < gap; i++) begin
            in_valid = 1'b0;
            @(negedge clk);
            if (quiet) chk(out_valid == 1'b0, "R9 idle output during stall", 64'(out_valid), 64'(0));
        end
        in_valid = 1'b1;
        in_data  = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (emits) chk(out_valid && out_data == w, "R10 word one cycle after acceptance",
                       64'({out_valid, out_data}), 64'({1'b1, w}));
    endtask

    task automatic run_cmd(input int op, input int n, input int style);
        logic [31:0] r;
        logic [31:0] w;
        logic [31:0] cmd;
        int          low;
        new_word(r);
        cmd = {r[31:16], 4'(op), 12'(n)};   // upper bits are noise (R2)
        send(cmd, style % 2, 1'b0, 1'b0);
        case (op)
            0, 2: begin   // R2 raw pass, R4 pixel run
                for (int k = 0; k < n; k++) begin
                    new_word(w);
                    exp_q.push_back({op == 2, w});
                    send(w, (k + style) % 3, 1'b1, 1'b1);
                end
            end
            1, 3: begin   // R3 raw repeat, R5 pixel repeat
                if (n > 0) begin
                    new_word(w);
                    for (int k = 0; k < n; k++) exp_q.push_back({op == 3, w});
                    send(w, style % 2, 1'b1, 1'b1);
                    low = 0;
                    while (!in_ready) begin
                        chk(out_valid && out_data == w, (op == 1) ? "R3 replay every cycle" : "R5 replay every cycle",
                            64'({out_valid, out_data}), 64'({1'b1, w}));
                        low++;
                        @(negedge clk);
                    end
                    chk(low == n - 1, (op == 1) ? "R3 input blocked N-1 cycles" : "R5 input blocked N-1 cycles",
                        64'(low), 64'(n - 1));
                end
            end
            default: ;    // R6, R7: nothing expected
        endcase
    endtask

    // Output monitor: every emitted word must be the next expected one.
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6/R7/R8 unexpected output", 64'({out_is_pixel, out_data}), 64'(0));
            end else begin
                logic [32:0] e;
                e = exp_q.pop_front();
                chk({out_is_pixel, out_data} == e, e[32] ? "R4/R5 pixel word" : "R2/R3 raw word",
                    64'({out_is_pixel, out_data}), 64'(e));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual=%0d cycles expected=completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'(0));
        chk(in_ready == 1'b1, "R1 in_ready in reset", 64'(in_ready), 64'(1));
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 idle after reset",
            64'({out_valid, in_ready}), 64'(1));

        run_cmd(0, 3, 0);      // R2 back-to-back raw words
        run_cmd(2, 4, 2);      // R4 with gaps, R9
        run_cmd(1, 0, 0);      // R8 zero-count repeat
        run_cmd(0, 1, 1);
        run_cmd(15, 5, 0);     // R6 nop with nonzero count
        run_cmd(3, 1, 0);      // R5 single copy

        for (int op = 0; op < 16; op++) begin
            for (int ni = 0; ni < 5; ni++) begin
                run_cmd(op, (ni == 4) ? 7 : ni, op + ni);
            end
        end

        run_cmd(3, 200, 1);    // R5 long run
        run_cmd(1, 4095, 0);   // R3 full-width count
        run_cmd(0, 2, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2/R4 every expected word emitted", 64'(exp_q.size()), 64'(0));
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule